// File: doc/BRIEF.md
# Transfer Segment Splitter for Aligned DMA Descriptors

This block prepares one serial-flash transfer for a descriptor-driven DMA engine. Software or an upstream sequencer first announces a transfer with its total byte count and how many memory segments make it up. If the transfer is short enough to go through the FIFO path, the block reports FIFO mode at once. Otherwise it collects the segments (base address and byte count each) over a valid/ready stream and checks that their lengths add up to the announced total. Only then does it emit any pieces.

Each segment is cut on a 32-byte grid into at most three pieces. The first is a short unaligned lead-in and the second a run whose start and length are both multiples of 32. The last is a short remainder. Pieces of zero length are skipped. The two short pieces are flagged as needing a bounce buffer. A downstream allocator and copier act on each piece; they are not part of this block. Each piece carries a flag telling whether more pieces of the same transfer follow. The downstream logic uses that flag to link its descriptors into a chain.

Top module: `seg_splitter`

## Requirements
- R1: The lead-in piece of a segment starts at the segment address. Its length is the smaller of the segment length and the distance from the address up to the next multiple of 32, which is zero for an address that is already a multiple of 32.
- R2: The aligned piece starts right after the lead-in. Its length is what remains of the segment rounded down to a multiple of 32. It is emitted with `piece_bounce` = 0.
- R3: The remainder piece starts right after the aligned piece and carries the rest of the segment.
- R4: A piece of length zero is never presented on the piece port.
- R5: Lead-in and remainder pieces carry `piece_bounce` = 1. Each is shorter than 32 bytes and lies inside one 1024-byte window.
- R6: When `xfer_len` > 64 and `xfer_nseg` is 0 or greater than 5, the cycle after the start `xfer_done` pulses with `xfer_err` = 1 and `xfer_dma` = 1. No segment is accepted and no piece is emitted.
- R7: When the accepted segment lengths do not sum to `xfer_len`, `xfer_done` pulses with `xfer_err` = 1 in the cycle after the last segment handshake. No piece is emitted.
- R8: When `xfer_len` ≤ 64, the cycle after the start `xfer_done` pulses with `xfer_dma` = 0 and `xfer_err` = 0. `seg_ready` stays low and no piece is emitted. This length test takes priority over the segment-count test.
- R9: Pieces come out in ascending address order within a segment, and segments in the order they were received. `piece_more` is 1 on every piece except the last of the transfer.
- R10: While `piece_valid` is high and `piece_ready` low, the piece outputs hold their values.
- R11: `seg_ready` is high only while segments are being collected. After an error the block is idle again and accepts a new transfer.
- R12: The cycle after the last piece (the one with `piece_more` = 0) is accepted, `xfer_done` pulses for one cycle with `xfer_dma` = 1 and `xfer_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Announces a transfer; taken only when idle |
| xfer_len | input | LEN_W | Declared total byte count |
| xfer_nseg | input | CNT_W | Number of segments to follow |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | ADDR_W | Segment base address |
| seg_len | input | LEN_W | Segment byte count |
| piece_valid | output | 1 | Piece offered |
| piece_ready | input | 1 | Downstream takes the piece |
| piece_addr | output | ADDR_W | Piece start address |
| piece_len | output | LEN_W | Piece byte count |
| piece_bounce | output | 1 | Piece needs a bounce buffer |
| piece_more | output | 1 | Further pieces follow |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_dma | output | 1 | With done: 1 = DMA mode, 0 = FIFO mode |
| xfer_err | output | 1 | With done: transfer rejected |

## Verification
The FIFO decision and the segment-count rejection are due one cycle after the start is sampled. A sum mismatch is due one cycle after the last segment handshake. Completion is due one cycle after the handshake of the piece without `piece_more`. The bench samples `xfer_done` at exactly the falling edge that follows each of those triggering edges. A reference model built with queues predicts every piece, and the bench compares each piece handshake against it at every falling edge. Some runs add a back-pressure pattern to show that pieces hold and that the order stays intact.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_EMIT    = 2'd2
    } split_state_e;

    typedef enum logic [1:0] {
        PH_LEAD  = 2'd0,
        PH_ALIGN = 2'd1,
        PH_REST  = 2'd2
    } piece_phase_e;

endpackage

// File: rtl/seg_store.sv
module seg_store #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17,
    parameter int DEPTH  = 5,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LEN_W-1:0]  rd_len
);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LEN_W-1:0]  len_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                len_q[g]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                addr_q[g] <= wr_addr;
                len_q[g]  <= wr_len;
            end
        end
    end

    always_comb begin
        rd_addr = '0;
        rd_len  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_addr = addr_q[i];
                rd_len  = len_q[i];
            end
        end
    end

endmodule

// File: rtl/piece_split.sv
module piece_split #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17,
    parameter int ALIGN  = 32
) (
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    output logic [ADDR_W-1:0] lead_addr,
    output logic [LEN_W-1:0]  lead_len,
    output logic [ADDR_W-1:0] align_addr,
    output logic [LEN_W-1:0]  align_len,
    output logic [ADDR_W-1:0] rest_addr,
    output logic [LEN_W-1:0]  rest_len
);

    localparam int OFS_W = $clog2(ALIGN);
    localparam logic [LEN_W-1:0] ALIGN_L = LEN_W'(ALIGN);

    logic [OFS_W-1:0] ofs;
    logic [LEN_W-1:0] gap;
    logic [LEN_W-1:0] after_lead;

    always_comb begin
        ofs        = seg_addr[OFS_W-1:0];
        gap        = (ofs == '0) ? '0 : (ALIGN_L - {{(LEN_W-OFS_W){1'b0}}, ofs});
        lead_len   = (seg_len < gap) ? seg_len : gap;
        after_lead = seg_len - lead_len;
        align_len  = {after_lead[LEN_W-1:OFS_W], {OFS_W{1'b0}}};
        rest_len   = after_lead - align_len;
        lead_addr  = seg_addr;
        align_addr = seg_addr + ADDR_W'(lead_len);
        rest_addr  = align_addr + ADDR_W'(align_len);
    end

endmodule

// File: rtl/seg_splitter.sv
module seg_splitter
    import seg_split_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 17,
    parameter int MAX_SEG  = 5,
    parameter int ALIGN    = 32,
    parameter int FIFO_MAX = 64,
    parameter int CNT_W    = $clog2(MAX_SEG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [CNT_W-1:0]  xfer_nseg,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [ADDR_W-1:0] seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    output logic              piece_valid,
    input  logic              piece_ready,
    output logic [ADDR_W-1:0] piece_addr,
    output logic [LEN_W-1:0]  piece_len,
    output logic              piece_bounce,
    output logic              piece_more,
    output logic              xfer_done,
    output logic              xfer_dma,
    output logic              xfer_err
);

    localparam int SUM_W = LEN_W + CNT_W;

    typedef struct packed {
        split_state_e       st;
        piece_phase_e       ph;
        logic [CNT_W-1:0]   nseg;
        logic [CNT_W-1:0]   idx;
        logic [LEN_W-1:0]   total;
        logic [SUM_W-1:0]   acc;
        logic               done;
        logic               dma;
        logic               err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_en;
    logic [ADDR_W-1:0] cur_seg_addr;
    logic [LEN_W-1:0]  cur_seg_len;
    logic [ADDR_W-1:0] lead_addr, align_addr, rest_addr;
    logic [LEN_W-1:0]  lead_len, align_len, rest_len;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_len;
    logic              cur_bounce;
    logic              cur_more;
    logic [SUM_W-1:0]  acc_next;
    logic              step;

    seg_store #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .DEPTH  (MAX_SEG),
        .IDX_W  (CNT_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ctl_q.idx),
        .wr_addr (seg_addr),
        .wr_len  (seg_len),
        .rd_idx  (ctl_q.idx),
        .rd_addr (cur_seg_addr),
        .rd_len  (cur_seg_len)
    );

    piece_split #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .ALIGN  (ALIGN)
    ) i_split (
        .seg_addr   (cur_seg_addr),
        .seg_len    (cur_seg_len),
        .lead_addr  (lead_addr),
        .lead_len   (lead_len),
        .align_addr (align_addr),
        .align_len  (align_len),
        .rest_addr  (rest_addr),
        .rest_len   (rest_len)
    );

    // Piece under the cursor
    always_comb begin
        unique case (ctl_q.ph)
            PH_ALIGN: begin
                cur_addr   = align_addr;
                cur_len    = align_len;
                cur_bounce = 1'b0;
            end
            PH_REST: begin
                cur_addr   = rest_addr;
                cur_len    = rest_len;
                cur_bounce = 1'b1;
            end
            default: begin
                cur_addr   = lead_addr;
                cur_len    = lead_len;
                cur_bounce = 1'b1;
            end
        endcase
        cur_more = (ctl_q.acc + SUM_W'(cur_len)) != SUM_W'(ctl_q.total);
    end

    // Next-state computation
    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        wr_en    = 1'b0;
        acc_next = ctl_q.acc + SUM_W'(seg_len);
        step     = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    if (xfer_len <= LEN_W'(FIFO_MAX)) begin
                        ctl_d.done = 1'b1;
                        ctl_d.dma  = 1'b0;
                    end else if (xfer_nseg == '0 || xfer_nseg > CNT_W'(MAX_SEG)) begin
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                        ctl_d.dma  = 1'b1;
                    end else begin
                        ctl_d.st    = ST_COLLECT;
                        ctl_d.nseg  = xfer_nseg;
                        ctl_d.total = xfer_len;
                        ctl_d.idx   = '0;
                        ctl_d.acc   = '0;
                        ctl_d.dma   = 1'b1;
                    end
                end
            end
            ST_COLLECT: begin
                if (seg_valid) begin
                    wr_en     = 1'b1;
                    ctl_d.acc = acc_next;
                    if (ctl_q.idx == ctl_q.nseg - CNT_W'(1)) begin
                        if (acc_next != SUM_W'(ctl_q.total)) begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.done = 1'b1;
                            ctl_d.err  = 1'b1;
                        end else begin
                            ctl_d.st  = ST_EMIT;
                            ctl_d.idx = '0;
                            ctl_d.ph  = PH_LEAD;
                            ctl_d.acc = '0;
                        end
                    end else begin
                        ctl_d.idx = ctl_q.idx + CNT_W'(1);
                    end
                end
            end
            ST_EMIT: begin
                step = (cur_len == '0) || piece_ready;
                if (step) begin
                    ctl_d.acc = ctl_q.acc + SUM_W'(cur_len);
                    if (cur_len != '0 && !cur_more) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        unique case (ctl_q.ph)
                            PH_LEAD:  ctl_d.ph = PH_ALIGN;
                            PH_ALIGN: ctl_d.ph = PH_REST;
                            default: begin
                                ctl_d.ph = PH_LEAD;
                                if (ctl_q.idx == ctl_q.nseg - CNT_W'(1)) begin
                                    ctl_d.st = ST_IDLE;
                                end else begin
                                    ctl_d.idx = ctl_q.idx + CNT_W'(1);
                                end
                            end
                        endcase
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, ph: PH_LEAD, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign seg_ready    = (ctl_q.st == ST_COLLECT);
    assign piece_valid  = (ctl_q.st == ST_EMIT) && (cur_len != '0);
    assign piece_addr   = cur_addr;
    assign piece_len    = cur_len;
    assign piece_bounce = cur_bounce;
    assign piece_more   = cur_more;
    assign xfer_done    = ctl_q.done;
    assign xfer_dma     = ctl_q.dma;
    assign xfer_err     = ctl_q.err;

endmodule

// File: rtl/seg_splitter_chk.sv
module seg_splitter_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17,
    parameter int ALIGN  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_ready,
    input logic              piece_valid,
    input logic              piece_ready,
    input logic [ADDR_W-1:0] piece_addr,
    input logic [LEN_W-1:0]  piece_len,
    input logic              piece_bounce,
    input logic              piece_more,
    input logic              xfer_done,
    input logic              xfer_err
);

    localparam int OFS_W = $clog2(ALIGN);

    a_r4_no_empty_piece: assert property (@(posedge clk) disable iff (!rst_n)
        piece_valid |-> piece_len != '0);

    a_r5_bounce_short: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_valid && piece_bounce) |-> piece_len < LEN_W'(ALIGN));

    a_r5_bounce_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_valid && piece_bounce) |-> (int'(piece_addr[9:0]) + int'(piece_len)) <= 1024);

    a_r2_body_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_valid && !piece_bounce) |->
            (piece_addr[OFS_W-1:0] == '0) && (piece_len[OFS_W-1:0] == '0));

    a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (piece_valid && !piece_ready) |=>
            (piece_valid && $stable(piece_addr) && $stable(piece_len)
             && $stable(piece_bounce) && $stable(piece_more)));

    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_ready && piece_valid));

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> xfer_done);

endmodule

bind seg_splitter seg_splitter_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .ALIGN  (ALIGN)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .seg_ready    (seg_ready),
    .piece_valid  (piece_valid),
    .piece_ready  (piece_ready),
    .piece_addr   (piece_addr),
    .piece_len    (piece_len),
    .piece_bounce (piece_bounce),
    .piece_more   (piece_more),
    .xfer_done    (xfer_done),
    .xfer_err     (xfer_err)
);

// File: tb/test_seg_splitter.sv
module test_seg_splitter;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 17;
    localparam int CNT_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_start = 1'b0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic [CNT_W-1:0]  xfer_nseg = '0;
    logic              seg_valid = 1'b0;
    logic              seg_ready;
    logic [ADDR_W-1:0] seg_addr = '0;
    logic [LEN_W-1:0]  seg_len = '0;
    logic              piece_valid;
    logic              piece_ready = 1'b1;
    logic [ADDR_W-1:0] piece_addr;
    logic [LEN_W-1:0]  piece_len;
    logic              piece_bounce;
    logic              piece_more;
    logic              xfer_done;
    logic              xfer_dma;
    logic              xfer_err;

    seg_splitter i_seg_splitter (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_start   (xfer_start),
        .xfer_len     (xfer_len),
        .xfer_nseg    (xfer_nseg),
        .seg_valid    (seg_valid),
        .seg_ready    (seg_ready),
        .seg_addr     (seg_addr),
        .seg_len      (seg_len),
        .piece_valid  (piece_valid),
        .piece_ready  (piece_ready),
        .piece_addr   (piece_addr),
        .piece_len    (piece_len),
        .piece_bounce (piece_bounce),
        .piece_more   (piece_more),
        .xfer_done    (xfer_done),
        .xfer_dma     (xfer_dma),
        .xfer_err     (xfer_err)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state
    int qa[$];
    int ql[$];
    int qb[$];
    int qm[$];
    int sa[8];
    int sl[8];
    bit exp_dma = 0;
    bit exp_err = 0;
    bit done_seen = 0;
    bit done_due = 0;
    bit bp_en = 0;
    int bp_cnt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                finish_run();
            end
        end
    end

    // back-pressure pattern, changed just after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            bp_cnt++;
            piece_ready = bp_en ? ((bp_cnt % 3) != 0) : 1'b1;
        end
    end

    // monitor: compare every piece handshake and done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_due) begin
                chk(xfer_done === 1'b1, "R12 done one cycle after last piece", int'(xfer_done), 1);
                done_due = 0;
            end
            if (xfer_done) begin
                chk(xfer_dma === exp_dma, "R8 R12 done mode", int'(xfer_dma), int'(exp_dma));
                chk(xfer_err === exp_err, "R6 R7 R12 done error", int'(xfer_err), int'(exp_err));
                done_seen = 1;
            end
            if (piece_valid && piece_ready) begin
                if (qa.size() == 0) begin
                    chk(0, "R4 R7 R8 unexpected piece", int'(piece_len), 0);
                end else begin
                    chk(int'(piece_addr) == qa[0], "R1 R2 R3 R9 piece address", int'(piece_addr), qa[0]);
                    chk(int'(piece_len) == ql[0], "R1 R2 R3 piece length", int'(piece_len), ql[0]);
                    chk(int'(piece_bounce) == qb[0], "R2 R5 bounce flag", int'(piece_bounce), qb[0]);
                    chk(int'(piece_more) == qm[0], "R9 continuation flag", int'(piece_more), qm[0]);
                    if (!piece_more) done_due = 1;
                    void'(qa.pop_front());
                    void'(ql.pop_front());
                    void'(qb.pop_front());
                    void'(qm.pop_front());
                end
            end
        end
    end

    task automatic push_piece(input int a, input int l, input int b);
        if (l > 0) begin
            qa.push_back(a);
            ql.push_back(l);
            qb.push_back(b);
            qm.push_back(1);
        end
    endtask

    task automatic run_xfer(input int total, input int n);
        int sum = 0;
        bit early;
        bit mism;
        for (int i = 0; i < n && i < 8; i++) sum += sl[i];
        early = (total <= 64) || (n == 0) || (n > 5);
        mism  = !early && (sum != total);
        exp_dma = (total > 64);
        exp_err = exp_dma && ((n == 0) || (n > 5) || mism);
        done_seen = 0;
        if (!exp_err && exp_dma) begin
            for (int i = 0; i < n; i++) begin
                int a = sa[i];
                int l = sl[i];
                int up = ((a + 31) / 32) * 32;
                int h = (up - a < l) ? (up - a) : l;
                int b = ((l - h) / 32) * 32;
                push_piece(a, h, 1);
                push_piece(a + h, b, 0);
                push_piece(a + h + b, l - h - b, 1);
            end
            if (qm.size() > 0) qm[qm.size() - 1] = 0;
        end
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_len   = LEN_W'(total);
        xfer_nseg  = CNT_W'(n);
        @(negedge clk);
        xfer_start = 1'b0;
        if (early) begin
            chk(xfer_done === 1'b1, "R6 R8 done one cycle after start", int'(xfer_done), 1);
            chk(seg_ready === 1'b0, "R6 R8 R11 no segment accepted", int'(seg_ready), 0);
            repeat (3) @(negedge clk);
            chk(seg_ready === 1'b0 && piece_valid === 1'b0, "R8 R11 idle after decision",
                int'(seg_ready) + int'(piece_valid), 0);
        end else begin
            for (int i = 0; i < n; i++) begin
                seg_valid = 1'b1;
                seg_addr  = ADDR_W'(sa[i]);
                seg_len   = LEN_W'(sl[i]);
                while (!seg_ready) @(negedge clk);
                @(negedge clk);
            end
            seg_valid = 1'b0;
            if (mism) begin
                chk(xfer_done === 1'b1 && xfer_err === 1'b1, "R7 mismatch error after last segment",
                    int'(xfer_done) + int'(xfer_err), 2);
                repeat (4) @(negedge clk);
                chk(piece_valid === 1'b0, "R7 no pieces after mismatch", int'(piece_valid), 0);
            end else begin
                for (int w = 0; w < 2000 && !done_seen; w++) @(negedge clk);
                chk(done_seen, "R12 transfer completed", int'(done_seen), 1);
                chk(qa.size() == 0, "R9 all predicted pieces seen", qa.size(), 0);
            end
        end
        qa.delete(); ql.delete(); qb.delete(); qm.delete();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(xfer_done === 1'b0 && piece_valid === 1'b0 && seg_ready === 1'b0 && xfer_err === 1'b0,
            "R11 reset state", int'(xfer_done) + int'(piece_valid) + int'(seg_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(seg_ready === 1'b0, "R11 seg_ready low when idle", int'(seg_ready), 0);

        // FIFO path: exactly 64 and small, count would be illegal too
        sa[0] = 'h100; sl[0] = 64;
        run_xfer(64, 1);
        run_xfer(10, 0);
        // count errors
        run_xfer(100, 0);
        run_xfer(200, 6);
        // length mismatch
        sa[0] = 'h1000; sl[0] = 50; sa[1] = 'h2000; sl[1] = 60;
        run_xfer(100, 2);
        // R11 recovery: aligned single segment right after an error
        sa[0] = 'h1000; sl[0] = 128;
        run_xfer(128, 1);
        // lead, aligned and rest pieces
        sa[0] = 'h1005; sl[0] = 100;
        run_xfer(100, 1);
        // near a 1 KiB window edge, rest only, lead only, empty segment
        sa[0] = 'h13F0; sl[0] = 80;
        sa[1] = 'h3000; sl[1] = 20;
        sa[2] = 'h2003; sl[2] = 10;
        sa[3] = 'h4000; sl[3] = 0;
        sa[4] = 'h5011; sl[4] = 300;
        run_xfer(410, 5);
        // same with back-pressure (R10)
        bp_en = 1;
        run_xfer(410, 5);
        sa[0] = 'h7007; sl[0] = 70;
        run_xfer(70, 1);
        bp_en = 0;
        // 65 bytes is the first length that takes the DMA path
        sa[0] = 'h801F; sl[0] = 65;
        run_xfer(65, 1);
        finish_run();
    end

endmodule